// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit resolves the operand of a load-to-accumulator instruction. A start strobe comes with a 3-bit mode code, a 4-bit register specifier and a 12-bit field. The field holds an address, an immediate value or a displacement, depending on the mode. The unit reads the register file through a combinational read port. It fetches words from a 4096-word memory through a request/valid interface. It returns a 12-bit effective address and a 16-bit operand, with a one-cycle done pulse.

The indirect modes need two memory reads in a row. The first read returns a pointer word, and its low 12 bits address the operand. Indexed and based modes both add a register to the field, and the sum wraps modulo 4096. The memory may answer any number of cycles after a request. The sequencer holds its request steady until the valid strobe arrives.

Top module: `opnd_addr_unit`

## Requirements
- R1: Mode 0 (immediate): the operand is the field zero-extended to 16 bits and the effective address is 0. No memory read is made, and done is high in the first cycle after start is sampled.
- R2: Mode 1 (direct): the effective address is the field and the operand is the memory word at that address, fetched with exactly one read.
- R3: Mode 2 (register): the operand is the full 16-bit value of the named register and the effective address is 0. No memory read is made, and done is high in the second cycle after start is sampled.
- R4: Mode 3 (indirect): the first read fetches the word at the field address. Its low 12 bits become the effective address, and a second read at that address returns the operand. Exactly two reads are made.
- R5: Mode 4 (register-indirect): the low 12 bits of the named register address a pointer word. The low 12 bits of that word become the effective address, and a second read at that address returns the operand. Exactly two reads are made.
- R6: Mode 5 (indexed): the effective address is (field + low 12 bits of the named register) mod 4096. The operand is read from that address in one read.
- R7: Mode 6 (based): the effective address is (low 12 bits of the named register + field) mod 4096. The operand is read from that address in one read.
- R8: Mode 7 is reserved. It sets the error output together with done, leaves address and operand at 0, and makes no memory read. The error output clears at the next start with a valid mode.
- R9: Once a memory request is raised, the request and its address hold steady until a cycle in which valid is seen, whatever the memory latency.
- R10: Done lasts one cycle. The effective address, operand and error outputs hold their values until the next accepted start. A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving one operand (taken only when idle) |
| modeIn | input | 3 | Addressing mode code, 0..6 valid, 7 reserved |
| regSelIn | input | 4 | Register specifier |
| fieldIn | input | 12 | Address, immediate or displacement field |
| regAddr | output | 4 | Register file read address |
| regData | input | 16 | Register file read data (combinational) |
| memReq | output | 1 | Memory read request, held until memValid |
| memAddr | output | 12 | Memory read address |
| memValid | input | 1 | Memory read data valid |
| memData | input | 16 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved mode was requested |
| eaOut | output | 12 | Resolved effective address |
| opOut | output | 16 | Fetched operand |

## Verification
The bench builds the unit with its default parameters: a 4-bit register specifier, a 12-bit address and a 16-bit word. At this size, every one of the 8 mode codes can be crossed with all 16 registers and a set of edge fields (0, 1, 0x800, 0xFFF and a mixed pattern). Register and memory contents come from arithmetic functions over the whole address space, so the wrap of indexed and based sums, the chained pointer reads and zero-extension are all reached. Memory latency cycles from 0 to 3 across the sweep.

// File: rtl/oau_pkg.sv
package oau_pkg;

  typedef enum logic [2:0] {
    MD_IMM  = 3'd0,
    MD_DIR  = 3'd1,
    MD_REG  = 3'd2,
    MD_IND  = 3'd3,
    MD_RIND = 3'd4,
    MD_IDX  = 3'd5,
    MD_BASE = 3'd6,
    MD_RSV  = 3'd7
  } modeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REGRD,
    ST_RDPTR,
    ST_RDOP,
    ST_DONE
  } stateT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldInstr;
    logic opFromField;
    logic eaFromField;
    logic ptrFromField;
    logic opFromReg;
    logic ptrFromReg;
    logic eaFromSum;
    logic eaFromMem;
    logic opFromMem;
    logic selPtr;
  } ctrlStrobeT;

endpackage

// File: rtl/oau_ctrl.sv
module oau_ctrl
  import oau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] modeIn,
  input  logic       memValid,
  output ctrlStrobeT stb,
  output logic       memReq,
  output logic       done,
  output logic       err,
  output logic       busy
);

  stateT state, nxt;
  modeT  modeQ;
  logic  errQ;

  always_comb begin
    stb    = '0;
    nxt    = state;
    memReq = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.ldInstr = 1'b1;
          case (modeT'(modeIn))
            MD_IMM: begin stb.opFromField  = 1'b1; nxt = ST_DONE;  end
            MD_DIR: begin stb.eaFromField  = 1'b1; nxt = ST_RDOP;  end
            MD_IND: begin stb.ptrFromField = 1'b1; nxt = ST_RDPTR; end
            MD_RSV: nxt = ST_DONE;
            default: nxt = ST_REGRD;
          endcase
        end
      end
      ST_REGRD: begin
        case (modeQ)
          MD_REG:  begin stb.opFromReg  = 1'b1; nxt = ST_DONE;  end
          MD_RIND: begin stb.ptrFromReg = 1'b1; nxt = ST_RDPTR; end
          default: begin stb.eaFromSum  = 1'b1; nxt = ST_RDOP;  end
        endcase
      end
      ST_RDPTR: begin
        memReq     = 1'b1;
        stb.selPtr = 1'b1;
        if (memValid) begin
          stb.eaFromMem = 1'b1;
          nxt = ST_RDOP;
        end
      end
      ST_RDOP: begin
        memReq = 1'b1;
        if (memValid) begin
          stb.opFromMem = 1'b1;
          nxt = ST_DONE;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= MD_IMM;
      errQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        modeQ <= modeT'(modeIn);
        errQ  <= (modeT'(modeIn) == MD_RSV);
      end
    end
  end

  assign done = (state == ST_DONE);
  assign busy = (state != ST_IDLE);
  assign err  = errQ;

  // R10
  single_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> done);

  // R1 R3 R8
  no_mem_for_local_modes_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (modeQ inside {MD_DIR, MD_IND, MD_RIND, MD_IDX, MD_BASE}));

endmodule

// File: rtl/oau_dp.sv
module oau_dp
  import oau_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int MEM_AW = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        stb,
  input  logic [REG_AW-1:0] regSelIn,
  input  logic [MEM_AW-1:0] fieldIn,
  input  logic [DATA_W-1:0] regData,
  input  logic [DATA_W-1:0] memData,
  output logic [REG_AW-1:0] regAddr,
  output logic [MEM_AW-1:0] memAddr,
  output logic [MEM_AW-1:0] eaOut,
  output logic [DATA_W-1:0] opOut
);

  logic [REG_AW-1:0] regSelQ;
  logic [MEM_AW-1:0] fieldQ;
  logic [MEM_AW-1:0] ptrQ;
  logic [MEM_AW-1:0] eaQ;
  logic [DATA_W-1:0] opQ;
  logic [MEM_AW-1:0] eaSum;

  // modulo 2**MEM_AW by truncation
  assign eaSum = fieldQ + regData[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regSelQ <= '0;
      fieldQ  <= '0;
      ptrQ    <= '0;
      eaQ     <= '0;
      opQ     <= '0;
    end else if (stb.ldInstr) begin
      regSelQ <= regSelIn;
      fieldQ  <= fieldIn;
      eaQ     <= stb.eaFromField  ? fieldIn : '0;
      opQ     <= stb.opFromField  ? DATA_W'(fieldIn) : '0;
      if (stb.ptrFromField) ptrQ <= fieldIn;
    end else begin
      if (stb.opFromReg)  opQ  <= regData;
      if (stb.ptrFromReg) ptrQ <= regData[MEM_AW-1:0];
      if (stb.eaFromSum)  eaQ  <= eaSum;
      if (stb.eaFromMem)  eaQ  <= memData[MEM_AW-1:0];
      if (stb.opFromMem)  opQ  <= memData;
    end
  end

  assign regAddr = regSelQ;
  assign memAddr = stb.selPtr ? ptrQ : eaQ;
  assign eaOut   = eaQ;
  assign opOut   = opQ;

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int MEM_AW = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        modeIn,
  input  logic [REG_AW-1:0] regSelIn,
  input  logic [MEM_AW-1:0] fieldIn,
  output logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regData,
  output logic              memReq,
  output logic [MEM_AW-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  output logic              done,
  output logic              err,
  output logic [MEM_AW-1:0] eaOut,
  output logic [DATA_W-1:0] opOut
);

  ctrlStrobeT stb;
  logic       busy;

  oau_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeIn   (modeIn),
    .memValid (memValid),
    .stb      (stb),
    .memReq   (memReq),
    .done     (done),
    .err      (err),
    .busy     (busy)
  );

  oau_dp #(
    .REG_AW (REG_AW),
    .MEM_AW (MEM_AW),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regSelIn (regSelIn),
    .fieldIn  (fieldIn),
    .regData  (regData),
    .memData  (memData),
    .regAddr  (regAddr),
    .memAddr  (memAddr),
    .eaOut    (eaOut),
    .opOut    (opOut)
  );

  // R9
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(eaOut) && $stable(opOut) && $stable(err)));

endmodule

// File: tb/opnd_addr_unit_tb.sv
`timescale 1ns/1ps
module opnd_addr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  modeIn = '0;
  logic [3:0]  regSelIn = '0;
  logic [11:0] fieldIn = '0;
  logic [3:0]  regAddr;
  logic [15:0] regData;
  logic        memReq;
  logic [11:0] memAddr;
  logic        memValid;
  logic [15:0] memData;
  logic        done, err;
  logic [11:0] eaOut;
  logic [15:0] opOut;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int nReads = 0;
  int stableBad = 0;
  int waitCnt = 0;
  logic [11:0] lastAddr = '0;

  always #4 clk = ~clk;

  function automatic logic [15:0] memF(input logic [11:0] a);
    logic [15:0] w;
    w = 16'(a) * 16'd40503;
    return w + 16'h1234;
  endfunction

  function automatic logic [15:0] regF(input logic [3:0] r);
    return {r, ~r, r, r} ^ 16'hA5C3;
  endfunction

  assign regData = regF(regAddr);

  opnd_addr_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .regSelIn(regSelIn), .fieldIn(fieldIn), .regAddr(regAddr),
    .regData(regData), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .done(done), .err(err),
    .eaOut(eaOut), .opOut(opOut)
  );

  // memory model: answers after lat waiting cycles, counts reads, watches address
  always @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memData  <= '0;
      waitCnt  <= 0;
    end else begin
      memValid <= 1'b0;
      if (memReq && !memValid) begin
        if (waitCnt != 0 && memAddr != lastAddr) stableBad <= stableBad + 1;
        lastAddr <= memAddr;
        if (waitCnt >= lat) begin
          memValid <= 1'b1;
          memData  <= memF(memAddr);
          waitCnt  <= 0;
          nReads   <= nReads + 1;
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input int md, input int r, input logic [11:0] f, input int lt);
    logic [11:0] expEa;
    logic [15:0] expOp;
    logic [11:0] p;
    int expReads;
    int expCyc;
    int rd0;
    int cyc;
    string req;
    expEa = '0; expOp = '0; expReads = 0; expCyc = 0;
    case (md)
      0: begin req = "R1"; expOp = {4'h0, f}; expCyc = 1; end
      1: begin req = "R2"; expEa = f; expOp = memF(f); expReads = 1; end
      2: begin req = "R3"; expOp = regF(4'(r)); expCyc = 2; end
      3: begin req = "R4"; expEa = memF(f)[11:0]; expOp = memF(expEa); expReads = 2; end
      4: begin req = "R5"; p = regF(4'(r))[11:0]; expEa = memF(p)[11:0];
               expOp = memF(expEa); expReads = 2; end
      5: begin req = "R6"; expEa = f + regF(4'(r))[11:0]; expOp = memF(expEa); expReads = 1; end
      6: begin req = "R7"; expEa = regF(4'(r))[11:0] + f; expOp = memF(expEa); expReads = 1; end
      default: begin req = "R8"; expCyc = 1; end
    endcase
    lat = lt;
    rd0 = nReads;
    @(negedge clk);
    modeIn = 3'(md); regSelIn = 4'(r); fieldIn = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, req, "done seen", 32'(done), 32'd1);
    chk(eaOut == expEa, req, "effective address", 32'(eaOut), 32'(expEa));
    chk(opOut == expOp, req, "operand", 32'(opOut), 32'(expOp));
    chk(err == (md == 7), req, "error flag", 32'(err), 32'(md == 7));
    chk((nReads - rd0) == expReads, req, "read count", 32'(nReads - rd0), 32'(expReads));
    if (expCyc != 0) chk(cyc == expCyc, req, "latency", 32'(cyc), 32'(expCyc));
    @(negedge clk);
    // R10 single-cycle pulse and hold
    chk(done == 1'b0, "R10", "done pulse width", 32'(done), 32'd0);
    chk(eaOut == expEa && opOut == expOp, "R10", "outputs held", 32'(opOut), 32'(expOp));
  endtask

  initial begin
    logic [11:0] fields [5];
    int cyc;
    fields[0] = 12'h000; fields[1] = 12'h001; fields[2] = 12'hFFF;
    fields[3] = 12'h800; fields[4] = 12'h5A3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 0 && memReq == 0 && err == 0, "R10", "reset controls", {done, memReq, err}, 0);
    chk(eaOut == 0 && opOut == 0, "R10", "reset results", {eaOut, opOut}, 0);

    for (int md = 0; md < 8; md++)
      for (int r = 0; r < 16; r++)
        for (int fi = 0; fi < 5; fi++)
          runOp(md, r, fields[fi], (r + fi) % 4);

    // R8 error clears at next valid start
    runOp(7, 3, 12'h123, 0);
    runOp(0, 3, 12'h456, 0);

    // R10 start ignored while busy; R9 long latency
    lat = 3;
    @(negedge clk);
    modeIn = 3'd1; regSelIn = 4'd2; fieldIn = 12'h3C7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    modeIn = 3'd0; fieldIn = 12'h111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    chk(eaOut == 12'h3C7, "R10", "busy start ignored ea", 32'(eaOut), 32'h3C7);
    chk(opOut == memF(12'h3C7), "R10", "busy start ignored op", 32'(opOut), 32'(memF(12'h3C7)));
    repeat (3) @(negedge clk);
    chk(opOut == memF(12'h3C7), "R10", "held after idle", 32'(opOut), 32'(memF(12'h3C7)));
    chk(stableBad == 0, "R9", "request address stable", 32'(stableBad), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule